// File: doc/BRIEF.md
# GPIO Controller with Routed Interrupts

This block is a register-mapped general purpose I/O controller for up to 32 lines. Software sets the value and the direction of each line and reads back the pin levels. Each line can also raise an interrupt. The trigger is a high level, a low level, a rising edge or a falling edge. The line's event then goes to one of several interrupt outputs, or to none.

Every input passes through a two-flop synchroniser before the data register or the interrupt logic sees it. The interrupt mask gates each line's event. A per-line routing byte steers the event to an output. Each output is the OR of every line routed to it, taken through one register stage.

The register port is a plain word-wide access port with no back-pressure. A write is taken on the clock edge where `bus_wr` is high. A read is taken on the edge where `bus_rd` is high, and `bus_rdata` holds the result from the following cycle until the next read. Only word accesses are defined, so bit n of every per-line register belongs to line n.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every register reads 0, `pin_out` and `pin_oe` are 0 and `irq_out` is 0, so all lines start as masked inputs.
- R2: A write to offset 0x04 sets `pin_out`, and a write to offset 0x08 sets `pin_oe`, where 1 drives the line. Both take effect one cycle after the write and read back unchanged.
- R3: A read of offset 0x00 returns the pin levels after a two-flop synchroniser. A pin change is visible in a read issued two cycles later. Bits at or above NLINES read 0.
- R4: A line whose bit in the mask register (offset 0x0C) is 0 never asserts any interrupt output.
- R5: Level mode has edge-select bit 0 (offset 0x14). With polarity bit 0 (offset 0x10) the line is active while low, and with polarity bit 1 it is active while high. The routed output rises on the third clock edge after the pin reaches its active level and stays high while the level holds.
- R6: Edge mode has edge-select bit 1. Polarity 1 selects rising edges and polarity 0 selects falling edges. Each edge gives a one-cycle pulse on the routed output on the third clock edge after the pin change.
- R7: Line j has a routing byte at bits [8*(j%4)+7 : 8*(j%4)] of the word at offset 0x20+4*(j/4). Bit 7 enables the route and bits 4:0 name the output. An index at or above NIRQ, or a clear enable bit, routes the line nowhere. The whole byte reads back as written.
- R8: Lines routed to the same output are OR-combined, so the output stays high while any of them is active.
- R9: The bypass register (offset 0x18) reads back what was written and has no effect on pins or interrupts.
- R10: Writes to the data register are ignored. Reads of unmapped offsets (such as 0x1C, or routing words beyond the last line) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid from the cycle after the read strobe |
| pin_in | input | NLINES | Asynchronous pin levels |
| pin_out | output | NLINES | Output values |
| pin_oe | output | NLINES | Output enables, 1 drives the line |
| irq_out | output | NIRQ | Interrupt outputs |

## Verification
The assertions check four things on every cycle. A fully cleared mask or a fully disabled routing table keeps every interrupt output low. Writes to the output and direction registers appear on the pins in the next cycle. A data read returns the synchroniser's value. The trigger decoding can only be shown by the bench's scenarios. These cover level persistence, the exact single-cycle edge pulse and its three-edge latency, falling versus rising selection, OR-sharing of an output, and out-of-range or disabled routes. The same holds for register readback, the bypass register having no effect, and reads of unmapped offsets.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_W = 32;
  localparam logic [7:0] OFS_DATA   = 8'h00;
  localparam logic [7:0] OFS_OUT    = 8'h04;
  localparam logic [7:0] OFS_DIR    = 8'h08;
  localparam logic [7:0] OFS_MASK   = 8'h0C;
  localparam logic [7:0] OFS_POL    = 8'h10;
  localparam logic [7:0] OFS_EDGE   = 8'h14;
  localparam logic [7:0] OFS_BYPASS = 8'h18;
  localparam logic [7:0] OFS_ROUTE  = 8'h20;
  localparam int ROUTE_EN_BIT = 7;
  localparam int ROUTE_IDX_W  = 5;
  localparam int LINES_PER_WORD = 4;
  typedef logic [ROUTE_IDX_W-1:0] route_idx_t;
  typedef logic [7:0] route_byte_t;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int ADDR_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr,
  input  logic                           rd,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [REG_W-1:0]               wdata,
  input  logic [NLINES-1:0]              data_in,
  output logic [NLINES-1:0]              out_q,
  output logic [NLINES-1:0]              dir_q,
  output logic [NLINES-1:0]              mask_q,
  output logic [NLINES-1:0]              pol_q,
  output logic [NLINES-1:0]              edge_q,
  output logic [NLINES-1:0]              route_en,
  output route_idx_t [NLINES-1:0]        route_idx,
  output logic [REG_W-1:0]               rdata
);
  localparam int NWORDS = (NLINES + LINES_PER_WORD - 1) / LINES_PER_WORD;

  route_byte_t [NLINES-1:0] route_q;
  logic [REG_W-1:0]         bypass_q;
  logic [REG_W-1:0]         rd_mux;

  function automatic logic [REG_W-1:0] widen(input logic [NLINES-1:0] v);
    logic [REG_W-1:0] t;
    t = '0;
    t[NLINES-1:0] = v;
    return t;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q    <= '0;
      dir_q    <= '0;
      mask_q   <= '0;
      pol_q    <= '0;
      edge_q   <= '0;
      bypass_q <= '0;
      route_q  <= '0;
    end else if (wr) begin
      case (addr)
        ADDR_W'(OFS_OUT):    out_q    <= wdata[NLINES-1:0];
        ADDR_W'(OFS_DIR):    dir_q    <= wdata[NLINES-1:0];
        ADDR_W'(OFS_MASK):   mask_q   <= wdata[NLINES-1:0];
        ADDR_W'(OFS_POL):    pol_q    <= wdata[NLINES-1:0];
        ADDR_W'(OFS_EDGE):   edge_q   <= wdata[NLINES-1:0];
        ADDR_W'(OFS_BYPASS): bypass_q <= wdata;
        default: ;
      endcase
      for (int j = 0; j < NLINES; j++) begin
        if (addr == ADDR_W'(int'(OFS_ROUTE) + 4 * (j / LINES_PER_WORD)))
          route_q[j] <= wdata[8*(j%LINES_PER_WORD) +: 8];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(OFS_DATA):   rd_mux = widen(data_in);
      ADDR_W'(OFS_OUT):    rd_mux = widen(out_q);
      ADDR_W'(OFS_DIR):    rd_mux = widen(dir_q);
      ADDR_W'(OFS_MASK):   rd_mux = widen(mask_q);
      ADDR_W'(OFS_POL):    rd_mux = widen(pol_q);
      ADDR_W'(OFS_EDGE):   rd_mux = widen(edge_q);
      ADDR_W'(OFS_BYPASS): rd_mux = bypass_q;
      default: ;
    endcase
    for (int w = 0; w < NWORDS; w++) begin
      if (addr == ADDR_W'(int'(OFS_ROUTE) + 4 * w)) begin
        for (int b = 0; b < LINES_PER_WORD; b++) begin
          if (w * LINES_PER_WORD + b < NLINES)
            rd_mux[8*b +: 8] = route_q[w * LINES_PER_WORD + b];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_route_split
    assign route_en[g]  = route_q[g][ROUTE_EN_BIT];
    assign route_idx[g] = route_q[g][ROUTE_IDX_W-1:0];
  end
endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] pin_in,
  input  logic [NLINES-1:0] pol,
  input  logic [NLINES-1:0] edge_sel,
  input  logic [NLINES-1:0] mask,
  output logic [NLINES-1:0] sync_out,
  output logic [NLINES-1:0] evt
);
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic meta_q, sync_q, prev_q;
    logic lvl_hit, edge_hit;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pin_in[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    always_comb begin
      lvl_hit  = pol[g] ? sync_q : ~sync_q;
      edge_hit = pol[g] ? (sync_q & ~prev_q) : (~sync_q & prev_q);
      evt[g]   = mask[g] & (edge_sel[g] ? edge_hit : lvl_hit);
    end

    assign sync_out[g] = sync_q;
  end
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int NIRQ   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NLINES-1:0]       evt,
  input  logic [NLINES-1:0]       route_en,
  input  route_idx_t [NLINES-1:0] route_idx,
  output logic [NIRQ-1:0]         irq_out
);
  logic [NIRQ-1:0] irq_next;

  for (genvar i = 0; i < NIRQ; i++) begin : g_out
    logic [NLINES-1:0] hits;
    for (genvar j = 0; j < NLINES; j++) begin : g_src
      assign hits[j] = evt[j] & route_en[j] & (route_idx[j] == route_idx_t'(i));
    end
    assign irq_next[i] = |hits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= irq_next;
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int NIRQ   = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  output logic [NIRQ-1:0]   irq_out
);
  logic [NLINES-1:0]       mask_q, pol_q, edge_q, route_en, data_sync, evt;
  route_idx_t [NLINES-1:0] route_idx;

  gpio_regs #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .data_in(data_sync), .out_q(pin_out), .dir_q(pin_oe),
    .mask_q(mask_q), .pol_q(pol_q), .edge_q(edge_q), .route_en(route_en),
    .route_idx(route_idx), .rdata(bus_rdata)
  );

  gpio_line_detect #(.NLINES(NLINES)) u_detect (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pol(pol_q), .edge_sel(edge_q),
    .mask(mask_q), .sync_out(data_sync), .evt(evt)
  );

  gpio_irq_route #(.NLINES(NLINES), .NIRQ(NIRQ)) u_route (
    .clk(clk), .rst_n(rst_n), .evt(evt), .route_en(route_en),
    .route_idx(route_idx), .irq_out(irq_out)
  );
endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int NIRQ   = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NLINES-1:0] pin_out,
  input logic [NLINES-1:0] pin_oe,
  input logic [NIRQ-1:0]   irq_out,
  input logic [NLINES-1:0] mask_q,
  input logic [NLINES-1:0] route_en,
  input logic [NLINES-1:0] data_sync
);
  function automatic logic [31:0] widen(input logic [NLINES-1:0] v);
    logic [31:0] t;
    t = '0;
    t[NLINES-1:0] = v;
    return t;
  endfunction

  p_mask_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> (irq_out == '0));

  p_no_route_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (route_en == '0) |=> (irq_out == '0));

  p_out_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_OUT)) |=> (pin_out == $past(bus_wdata[NLINES-1:0])));

  p_dir_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_DIR)) |=> (pin_oe == $past(bus_wdata[NLINES-1:0])));

  p_data_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(OFS_DATA)) |=> (bus_rdata == $past(widen(data_sync))));
endmodule

bind gpio_irq_router gpio_irq_router_chk #(.NLINES(NLINES), .NIRQ(NIRQ), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq_out(irq_out), .mask_q(mask_q), .route_en(route_en), .data_sync(data_sync)
);

// File: tb/gpio_irq_router_tb.sv
module gpio_irq_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NLINES = 32;
  localparam int NIRQ = 4;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NLINES-1:0] pin_in = '0;
  logic [NLINES-1:0] pin_out, pin_oe;
  logic [NIRQ-1:0] irq_out;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;
  logic rd_seen = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_router #(.NLINES(NLINES), .NIRQ(NIRQ), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data as each read result appears
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb.size() == 0) begin
        check(bus_rdata, 32'hx, "scoreboard underflow");
      end else begin
        rd_item_t it;
        it = sb.pop_front();
        check(bus_rdata, it.exp, it.tag);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd_item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic [NIRQ-1:0] exp, input string tag);
    check(32'(irq_out), 32'(exp), tag);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    check(32'(pin_out), 0, "R1 pin_out");
    check(32'(pin_oe), 0, "R1 pin_oe");
    chk_irq(0, "R1 irq_out");
    rd(8'h0C, 0, "R1 mask");
    rd(8'h10, 0, "R1 pol");
    rd(8'h20, 0, "R1 route");
    rd(8'h18, 0, "R1 bypass");

    // R2 output and direction
    wr(8'h04, 32'hA5A5_0F0F);
    check(32'(pin_out), 32'hA5A5_0F0F, "R2 pin_out");
    wr(8'h08, 32'hFFFF_0000);
    check(32'(pin_oe), 32'hFFFF_0000, "R2 pin_oe");
    rd(8'h04, 32'hA5A5_0F0F, "R2 out readback");
    rd(8'h08, 32'hFFFF_0000, "R2 dir readback");

    // R3 data register after synchroniser
    pin_in = 32'h1234_5678;
    rd(8'h00, 32'h0, "R3 data before sync");
    cyc(2);
    rd(8'h00, 32'h1234_5678, "R3 data");
    // R10 data register write ignored
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h1234_5678, "R10 data write ignored");
    rd(8'h1C, 0, "R10 unmapped 0x1C");
    rd(8'h40, 0, "R10 unmapped 0x40");

    // R9 bypass register
    wr(8'h18, 32'hDEAD_BEEF);
    rd(8'h18, 32'hDEAD_BEEF, "R9 bypass readback");
    check(32'(pin_out), 32'hA5A5_0F0F, "R9 pin_out unchanged");
    check(32'(pin_oe), 32'hFFFF_0000, "R9 pin_oe unchanged");
    chk_irq(0, "R9 irq unchanged");

    // interrupt setup, all masked
    pin_in = '0;
    cyc(4);
    wr(8'h10, 32'h0000_00F3);
    wr(8'h14, 32'h0000_0006);
    wr(8'h20, 32'h8083_8382);
    wr(8'h24, 32'h0185_8181);
    rd(8'h20, 32'h8083_8382, "R7 route readback word0");
    rd(8'h24, 32'h0185_8181, "R7 route readback word1");

    // R5 level high, line 0 -> irq 2
    wr(8'h0C, 32'h1);
    cyc(2);
    chk_irq(0, "R5 idle level high");
    pin_in[0] = 1'b1;
    cyc(2);
    chk_irq(0, "R5 latency edge 2");
    cyc(1);
    chk_irq(4'b0100, "R5 level high asserted");
    cyc(5);
    chk_irq(4'b0100, "R5 level held");
    // R4 mask clear
    wr(8'h0C, 32'h0);
    cyc(2);
    chk_irq(0, "R4 masked line silent");
    pin_in[0] = 1'b0;
    cyc(4);

    // R6 rising edge, line 1 -> irq 3
    wr(8'h0C, 32'h2);
    pin_in[1] = 1'b1;
    cyc(2);
    chk_irq(0, "R6 rise latency");
    cyc(1);
    chk_irq(4'b1000, "R6 rise pulse");
    cyc(1);
    chk_irq(0, "R6 rise pulse one cycle");
    cyc(4);
    chk_irq(0, "R6 no event while high");

    // R6 falling edge, line 2 -> irq 3
    wr(8'h0C, 32'h0);
    pin_in[2] = 1'b1;
    cyc(4);
    wr(8'h0C, 32'h4);
    cyc(2);
    chk_irq(0, "R6 rising ignored in falling mode");
    pin_in[2] = 1'b0;
    cyc(2);
    chk_irq(0, "R6 fall latency");
    cyc(1);
    chk_irq(4'b1000, "R6 fall pulse");
    cyc(1);
    chk_irq(0, "R6 fall pulse one cycle");

    // R5 level low, line 3 -> irq 0
    wr(8'h0C, 32'h8);
    cyc(1);
    chk_irq(4'b0001, "R5 level low asserted");
    pin_in[3] = 1'b1;
    cyc(2);
    chk_irq(4'b0001, "R5 level low held before sync");
    cyc(1);
    chk_irq(0, "R5 level low released");

    // R8 shared output, lines 4 and 5 -> irq 1
    wr(8'h0C, 32'h30);
    pin_in[4] = 1'b1;
    cyc(3);
    chk_irq(4'b0010, "R8 line4 on irq1");
    pin_in[4] = 1'b0; pin_in[5] = 1'b1;
    cyc(5);
    chk_irq(4'b0010, "R8 line5 on irq1");
    pin_in[4] = 1'b1;
    cyc(4);
    chk_irq(4'b0010, "R8 both on irq1");
    pin_in[4] = 1'b0; pin_in[5] = 1'b0;
    cyc(4);
    chk_irq(0, "R8 both released");

    // R7 out-of-range index (line 6) and disabled route (line 7)
    wr(8'h0C, 32'hC0);
    pin_in[6] = 1'b1; pin_in[7] = 1'b1;
    cyc(3);
    chk_irq(0, "R7 unrouted lines edge 3");
    cyc(4);
    chk_irq(0, "R7 unrouted lines held");

    cyc(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule